// File: doc/BRIEF.md
# OTP Array Security Access Controller

The controller sits in front of two behavioural one-time-programmable stores: a user code array and a smaller encryption key array. Two sticky lock bits decide which requests may reach them. One lock stops all further writes and also hides the key. The other lock stops read-back of both arrays. The lock levels themselves can always be read. Each request is a single command with an opcode, an address and a data byte. The block answers every accepted command with one response pulse that carries a data byte and an error flag.

A user-array read-back is scrambled. The stored byte is XNORed with the key byte that the low address bits select. An erased key (all ones) therefore returns the plain data, and an all-zero key returns its complement. Programming can only clear bits, so cells and locks never return to the erased state except through reset.

The control sequencer has six named states. S_IDLE accepts a request (IDLE→CHECK). S_CHECK judges it against the locks and branches to S_REFUSE (denied), S_WRITE (opcodes 1, 3, 5, 6) or S_FETCH (opcodes 0, 2, 4, 7). Each of those three states moves to S_DONE, which drives the response for one cycle and returns to S_IDLE.

Top module: `otp_security_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and lock_status is 2'b00. Every user cell and every key byte holds 8'hFF.
- R2: A request is accepted at a rising edge where req_valid and req_ready are both 1. rsp_valid is 1 for exactly the one cycle that begins at the second rising edge after the accepting edge. req_ready is 0 from the accepting edge until the edge where rsp_valid falls.
- R3: Opcode 1 (user program) and opcode 3 (key program) store old AND req_wdata. A bit at 0 never returns to 1.
- R4: Opcode 2 (user verify) returns the user byte at req_addr XNOR the key byte at index req_addr mod KEY_DEPTH.
- R5: Opcode 4 (key verify) returns the key byte at index req_addr mod KEY_DEPTH. Key programming uses the same index.
- R6: Opcode 5 sets the program lock and opcode 6 sets the verify lock. Both ignore req_addr and req_wdata, both are always allowed, and both stay set until reset.
- R7: While the program lock is set, opcodes 1, 3 and 4 are refused. Opcode 2 is still served.
- R8: While the verify lock is set, opcodes 2 and 4 are refused.
- R9: Opcode 7 is always served. It returns the program lock on bit 7 and the verify lock on bit 6, with the other bits 0. lock_status[1] shows the program lock and lock_status[0] shows the verify lock.
- R10: A refused request responds with rsp_err=1 and rsp_rdata=0 and changes no storage. A served request responds with rsp_err=0. Program commands and opcode 0 return rsp_rdata=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; erases the model |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Opcode 0..7 |
| req_addr | input | ADDR_W | User array address; low bits pick the key byte |
| req_wdata | input | DATA_W | Program data (0 bits clear cells) |
| req_ready | output | 1 | Controller is in S_IDLE and can accept a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Response data byte |
| rsp_err | output | 1 | Request was refused |
| lock_status | output | 2 | {program lock, verify lock} |

## Verification
A lost or falsely set lock shows up at once on lock_status and on the next opcode 7 read. It also makes the next gated command answer with the wrong error flag. A corrupted cell or key byte stays hidden until that address is verified. The bench therefore verifies every address after each locking phase, and it checks random reads against a model of the contents. A sequencer that skips or repeats a state shifts rsp_valid away from its fixed slot, and the timing check on every request catches that within three cycles.

// File: rtl/otp_guard_pkg.sv
package otp_guard_pkg;

    typedef enum logic [2:0] {
        OP_NOP        = 3'd0,
        OP_PROG_USER  = 3'd1,
        OP_VER_USER   = 3'd2,
        OP_PROG_KEY   = 3'd3,
        OP_VER_KEY    = 3'd4,
        OP_SET_LOCK1  = 3'd5,
        OP_SET_LOCK2  = 3'd6,
        OP_READ_LOCKS = 3'd7
    } otp_op_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_CHECK  = 3'd1,
        S_WRITE  = 3'd2,
        S_FETCH  = 3'd3,
        S_REFUSE = 3'd4,
        S_DONE   = 3'd5
    } ctrl_state_e;

    // Permission rule: program lock gates writes and key read-back,
    // verify lock gates both array read-backs.
    function automatic logic op_allowed(input otp_op_e op,
                                        input logic prog_lock,
                                        input logic ver_lock);
        logic ok;
        unique case (op)
            OP_PROG_USER:  ok = !prog_lock;
            OP_PROG_KEY:   ok = !prog_lock;
            OP_VER_USER:   ok = !ver_lock;
            OP_VER_KEY:    ok = !prog_lock && !ver_lock;
            default:       ok = 1'b1;
        endcase
        return ok;
    endfunction

    function automatic logic op_is_write(input otp_op_e op);
        return (op == OP_PROG_USER) || (op == OP_PROG_KEY) ||
               (op == OP_SET_LOCK1) || (op == OP_SET_LOCK2);
    endfunction

endpackage

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
    parameter int DEPTH  = 64,
    parameter int WIDTH  = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] cells [DEPTH];

    // Programming can only pull bits from 1 to 0.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (we) begin
            cells[idx] <= cells[idx] & wdata;
        end
    end

    assign rdata = cells[idx];

    // A programmed word never gains a 1 bit.
    assert_cell_no_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (idx != $past(idx)) || ((rdata & ~$past(rdata)) == '0));

    // Without a write strobe, the word at a held index is stable.
    assert_cell_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> (idx != $past(idx)) || $stable(rdata));

endmodule

// File: rtl/otp_lock_bits.sv
module otp_lock_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic set_prog_lock,
    input  logic set_ver_lock,
    output logic prog_lock,
    output logic ver_lock
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_lock <= 1'b0;
            ver_lock  <= 1'b0;
        end else begin
            if (set_prog_lock) prog_lock <= 1'b1;
            if (set_ver_lock)  ver_lock  <= 1'b1;
        end
    end

    assert_prog_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_lock |=> prog_lock);

    assert_ver_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ver_lock |=> ver_lock);

    assert_lock_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_lock) |-> $past(set_prog_lock));

endmodule

// File: rtl/otp_verify_scramble.sv
module otp_verify_scramble #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] plain,
    input  logic [WIDTH-1:0] key,
    output logic [WIDTH-1:0] scrambled
);

    assign scrambled = ~(plain ^ key);

    always_comb begin
        if (key == '0) begin
            assert_zero_key_complement_R4: assert (scrambled == ~plain);
        end
        if (key == '1) begin
            assert_erased_key_plain_R4: assert (scrambled == plain);
        end
    end

endmodule

// File: rtl/otp_security_ctrl.sv
module otp_security_ctrl
    import otp_guard_pkg::*;
#(
    parameter int USER_DEPTH = 64,
    parameter int KEY_DEPTH  = 32,
    parameter int DATA_W     = 8,
    localparam int ADDR_W    = $clog2(USER_DEPTH),
    localparam int KEY_W     = $clog2(KEY_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic [1:0]        lock_status
);

    ctrl_state_e       state_q, state_d;
    otp_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;

    logic              accept;
    logic              allow;
    logic              user_we, key_we, set_l1, set_l2;
    logic              prog_lock, ver_lock;
    logic [DATA_W-1:0] user_rdata, key_rdata, scr_data, fetch_data, lock_byte;

    assign accept = req_valid && (state_q == S_IDLE);
    assign allow  = op_allowed(op_q, prog_lock, ver_lock);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_NOP;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q    <= otp_op_e'(req_op);
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_d = S_CHECK;
            S_CHECK: begin
                if (!allow)                state_d = S_REFUSE;
                else if (op_is_write(op_q)) state_d = S_WRITE;
                else                        state_d = S_FETCH;
            end
            S_WRITE:  state_d = S_DONE;
            S_FETCH:  state_d = S_DONE;
            S_REFUSE: state_d = S_DONE;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // ---------------- outputs and strobes ----------------
    always_comb begin
        user_we = 1'b0;
        key_we  = 1'b0;
        set_l1  = 1'b0;
        set_l2  = 1'b0;
        if (state_q == S_WRITE) begin
            unique case (op_q)
                OP_PROG_USER: user_we = 1'b1;
                OP_PROG_KEY:  key_we  = 1'b1;
                OP_SET_LOCK1: set_l1  = 1'b1;
                OP_SET_LOCK2: set_l2  = 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        lock_byte = '0;
        lock_byte[DATA_W-1] = prog_lock;
        lock_byte[DATA_W-2] = ver_lock;
    end

    always_comb begin
        unique case (op_q)
            OP_VER_USER:   fetch_data = scr_data;
            OP_VER_KEY:    fetch_data = key_rdata;
            OP_READ_LOCKS: fetch_data = lock_byte;
            default:       fetch_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                S_FETCH:  begin rdata_q <= fetch_data; err_q <= 1'b0; end
                S_WRITE:  begin rdata_q <= '0;         err_q <= 1'b0; end
                S_REFUSE: begin rdata_q <= '0;         err_q <= 1'b1; end
                default: ;
            endcase
        end
    end

    assign req_ready   = (state_q == S_IDLE);
    assign rsp_valid   = (state_q == S_DONE);
    assign rsp_rdata   = rdata_q;
    assign rsp_err     = err_q;
    assign lock_status = {prog_lock, ver_lock};

    // ---------------- storage ----------------
    otp_cell_array #(.DEPTH(USER_DEPTH), .WIDTH(DATA_W)) u_user (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (user_we),
        .idx   (addr_q),
        .wdata (wdata_q),
        .rdata (user_rdata)
    );

    otp_cell_array #(.DEPTH(KEY_DEPTH), .WIDTH(DATA_W)) u_key (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (key_we),
        .idx   (addr_q[KEY_W-1:0]),
        .wdata (wdata_q),
        .rdata (key_rdata)
    );

    otp_verify_scramble #(.WIDTH(DATA_W)) u_scr (
        .plain     (user_rdata),
        .key       (key_rdata),
        .scrambled (scr_data)
    );

    otp_lock_bits u_locks (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_prog_lock (set_l1),
        .set_ver_lock  (set_l2),
        .prog_lock     (prog_lock),
        .ver_lock      (ver_lock)
    );

    // ---------------- assertions ----------------
    assert_busy_during_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_no_write_when_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (user_we || key_we) |-> !lock_status[1]);

    assert_key_hidden_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err && op_q == OP_VER_KEY) |-> !lock_status[1]);

    assert_verify_hidden_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err && (op_q == OP_VER_USER || op_q == OP_VER_KEY))
        |-> !lock_status[0]);

    assert_lock_readout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && op_q == OP_READ_LOCKS)
        |-> (!rsp_err && rsp_rdata[DATA_W-1] == lock_status[1]
             && rsp_rdata[DATA_W-2] == lock_status[0]));

    assert_refused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

endmodule

// File: tb/otp_security_ctrl_test.sv
module otp_security_ctrl_test;

    localparam int UD = 64;
    localparam int KD = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [5:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       req_ready, rsp_valid, rsp_err;
    logic [7:0] rsp_rdata;
    logic [1:0] lock_status;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic [7:0] m_user [UD];
    logic [7:0] m_key  [KD];
    logic       m_l1, m_l2;

    always #5 clk = ~clk;

    otp_security_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .lock_status(lock_status)
    );

    function automatic string req_of(int op);
        case (op)
            1, 3: return "R3/R7";
            2:    return "R4/R8";
            4:    return "R5/R7/R8";
            5, 6: return "R6";
            7:    return "R9";
            default: return "R10";
        endcase
    endfunction

    // Expected response per the requirements; also updates the model.
    function automatic void predict(input int op, input int addr, input logic [7:0] wd,
                                    output logic [7:0] rd, output logic er);
        int k;
        k  = addr % KD;
        rd = 8'h00;
        er = 1'b0;
        case (op)
            1: if (m_l1) er = 1; else m_user[addr] = m_user[addr] & wd;
            3: if (m_l1) er = 1; else m_key[k] = m_key[k] & wd;
            2: if (m_l2) er = 1; else rd = ~(m_user[addr] ^ m_key[k]);
            4: if (m_l1 || m_l2) er = 1; else rd = m_key[k];
            5: m_l1 = 1;
            6: m_l2 = 1;
            7: rd = {m_l1, m_l2, 6'b0};
            default: ;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run(input int op, input int addr, input logic [7:0] wd);
        logic [7:0] erd;
        logic       eer;
        bit         tim;
        predict(op, addr, wd, erd, eer);
        @(negedge clk);
        tim = req_ready;
        req_valid = 1'b1; req_op = op[2:0]; req_addr = addr[5:0]; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        tim &= !rsp_valid && !req_ready;
        @(negedge clk);
        tim &= !rsp_valid && !req_ready;
        @(negedge clk);
        tim &= rsp_valid && !req_ready;
        check({rsp_err, rsp_rdata} == {eer, erd}, req_of(op), $sformatf("op%0d addr%0d err,data", op, addr),
              {23'd0, rsp_err, rsp_rdata}, {23'd0, eer, erd});
        check(lock_status == {m_l1, m_l2}, "R9", "lock_status",
              {30'd0, lock_status}, {30'd0, m_l1, m_l2});
        @(negedge clk);
        tim &= !rsp_valid && req_ready;
        check(tim, "R2", "response timing", {31'd0, tim}, 32'd1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < UD; i++) m_user[i] = 8'hFF;
        for (int i = 0; i < KD; i++) m_key[i] = 8'hFF;
        m_l1 = 0; m_l2 = 0;
        @(negedge clk);
        check(req_ready && !rsp_valid && lock_status == 2'b00, "R1", "reset outputs",
              {29'd0, req_ready, rsp_valid, lock_status[0]}, 32'h4);
    endtask

    task automatic sweep();
        for (int a = 0; a < UD; a++) run(2, a, 8'h00);
        for (int a = 0; a < KD; a++) run(4, a, 8'h00);
    endtask

    task automatic random_ops(input int n, input int max_op);
        for (int i = 0; i < n; i++) begin
            int op;
            logic [7:0] d;
            op = $urandom_range(0, max_op);
            if ((op == 5 || op == 6) && max_op < 5) op = 7;
            d = ($urandom_range(0, 3) == 0) ? 8'($urandom) : (8'($urandom) | 8'($urandom));
            run(op, $urandom_range(0, UD - 1), d);
        end
    endtask

    initial begin
        void'($urandom(32'd24681));
        do_reset();
        // R1: erased contents
        sweep();
        // R4: zero key gives complement; R5 aliasing by mod KEY_DEPTH
        run(1, 3, 8'h5A);
        run(2, 3, 8'h00);
        run(3, 35, 8'h00);
        run(4, 3, 8'h00);
        run(2, 3, 8'h00);
        run(2, 35, 8'h00);
        // R3: programming cannot restore ones
        run(1, 3, 8'hFF);
        run(2, 3, 8'h00);
        // R10: opcode 0 returns zero
        run(0, 7, 8'hAB);
        random_ops(300, 4);
        sweep();
        // R6/R7: program lock, address/data ignored
        run(5, 17, 8'h00);
        run(7, 0, 8'h00);
        run(1, 9, 8'h00);
        run(3, 9, 8'h00);
        run(4, 9, 8'h00);
        run(2, 9, 8'h00);
        random_ops(200, 5);
        sweep();
        // R8: verify lock on top
        run(6, 63, 8'h12);
        run(7, 0, 8'h00);
        random_ops(150, 7);
        sweep();
        // Reset clears everything; verify lock alone
        do_reset();
        sweep();
        run(6, 0, 8'h00);
        run(1, 4, 8'h0F);
        run(3, 4, 8'hF0);
        run(2, 4, 8'h00);
        run(4, 4, 8'h00);
        run(5, 0, 8'h00);
        run(7, 0, 8'h00);
        random_ops(100, 7);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule